// File: doc/BRIEF.md
# Statically Scheduled Predicated Word Processor Element

This block is one tile of a time-multiplexed compute fabric. A fixed program of `NUM_SLOTS` instruction words sits in a small slot store. While `run` is high, one slot executes per clock. The whole program repeats without change, and one full pass is one user cycle. The element has no branches and no program counter control. Conditional work is done by predicating individual instructions on a sticky compare flag or on one of two externally driven predicate bits. Those bits come from a bit-level logic network that may sit in a neighbouring tile.

Word storage is a single 64-entry node address space:
- a register bank R and a register bank X, which only the element's own instructions write;
- four small neighbour banks, which only the four router write ports fill;
- a hole that reads as zero.

A separate data memory serves loads and stores. One input word port and one output word port with a valid strobe connect the element to the outside.

Wire and register semantics of a mapped circuit come from slot order. A value written in an earlier slot is seen by a later slot in the same user cycle, so it behaves as a wire. A value read before the slot that overwrites it keeps last cycle's content, so it behaves as a register. The program store is loaded through a plain write port while `run` is low.

Top module: `slot_pe`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `slot_idx` is 0, `io_out_vld` is 0 and `io_out` is 0. Reset also clears the compare flag and all R, X and neighbour words.
- R2: With `run` high, `slot_idx` advances by one per clock and wraps from `NUM_SLOTS-1` to 0. With `run` low, `slot_idx` returns to and holds 0, and no instruction has any effect.
- R3: The instruction word is 34 bits:
  - bits 33:30 are the opcode;
  - bits 29:28 are the predicate select;
  - bits 27:22 are operand A;
  - bits 21:16 are operand B;
  - bits 15:0 are the immediate.

  The opcodes are 0 no-op, 1 load, 2 store, 3 input load, 4 output store, 5 add-immediate, 6 add and 7 compare. Codes 8 to 15 act as no-ops.
- R4: The node address map is:
  - 0–15: R;
  - 16–31: X;
  - 32–35: north bank;
  - 36–39: south bank;
  - 40–43: east bank;
  - 44–47: west bank;
  - 48–63: read as zero.

  An instruction that writes to an address of 32 or above changes nothing.
- R5: The router port for direction d writes `nb_data[32d+31:32d]` into word `nb_addr[2d+1:2d]` of that direction's bank at the clock edge when `nb_we[d]` is high. Direction d runs north 0, south 1, east 2, west 3.
- R6: Input load writes `io_in` into node A. Output store puts node B on `io_out` and raises `io_out_vld` for exactly the clock after the executing slot. At all other times `io_out` holds its value.
- R7: Add-immediate writes node B plus the sign-extended immediate into node A. Add writes node A plus node B into node A. Both wrap modulo 2^32.
- R8: The data memory address is (node base + immediate) modulo `DMEM_DEPTH`. For a store the base is node A, and the store writes node B. For a load the base is node B, and the load writes the addressed word into node A.
- R9: Compare sets the flag when node B is non-zero and clears it otherwise. The flag keeps its value until the next compare that executes.
- R10: The predicate select chooses the condition for the instruction: 0 always, 1 the compare flag, 2 `pred_in[0]`, 3 `pred_in[1]`. An instruction whose condition is false writes no node or data word, raises no strobe and leaves the flag unchanged.
- R11: Within one user cycle, a slot reads what an earlier slot wrote to a node or data word. A slot that reads a word before the slot that writes it sees the value from the previous user cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Execute slots when high; hold at slot 0 when low |
| prog_we | input | 1 | Program store write enable |
| prog_addr | input | 4 | Program slot to write |
| prog_data | input | 34 | Instruction word to write |
| io_in | input | 32 | External input word for input load |
| pred_in | input | 2 | Bit-level predicate inputs |
| nb_we | input | 4 | Router write enables, one per direction |
| nb_addr | input | 8 | Router word index, 2 bits per direction |
| nb_data | input | 128 | Router write data, 32 bits per direction |
| io_out | output | 32 | Output word from the last output store |
| io_out_vld | output | 1 | One-clock strobe for a new output word |
| slot_idx | output | 4 | Slot executing in this clock |

## Verification
The assertions take three things for granted:
- `run` is raised and lowered only at slot 0, so a user cycle is never cut short;
- the program store is not rewritten while `run` is high;
- `io_in`, `pred_in` and router writes are meant for whole user cycles.

The stimulus honours all three. It changes `io_in` and `pred_in` only on the clock before slot 0 executes. It loads programs only with `run` low. It issues router writes either while idle or in slot 0, ahead of the later slots that read those words. Because the element's data memory is not reset, every program reads only data words that it wrote earlier.

// File: rtl/slot_pe_pkg.sv
package slot_pe_pkg;

    localparam int NODE_AW = 6;
    localparam int IMM_W   = 16;
    localparam int INSTR_W = 4 + 2 + 2 * NODE_AW + IMM_W;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_LOAD   = 4'd1,
        OP_STORE  = 4'd2,
        OP_IOLD   = 4'd3,
        OP_IOST   = 4'd4,
        OP_ADDI   = 4'd5,
        OP_ADD    = 4'd6,
        OP_CMP    = 4'd7
    } op_e;

    typedef enum logic [1:0] {
        PR_ALWAYS = 2'd0,
        PR_FLAG   = 2'd1,
        PR_BIT0   = 2'd2,
        PR_BIT1   = 2'd3
    } pred_e;

    typedef struct packed {
        op_e                 op;
        pred_e               pred;
        logic [NODE_AW-1:0]  a;
        logic [NODE_AW-1:0]  b;
        logic [IMM_W-1:0]    imm;
    } instr_t;

endpackage

// File: rtl/slot_pe_seq.sv
module slot_pe_seq
    import slot_pe_pkg::*;
#(
    parameter int NUM_SLOTS = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          run,
    input  logic                          prog_we,
    input  logic [$clog2(NUM_SLOTS)-1:0]  prog_addr,
    input  logic [INSTR_W-1:0]            prog_data,
    output logic [$clog2(NUM_SLOTS)-1:0]  slot,
    output instr_t                        instr
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

    logic [SLOT_W-1:0]  slot_d, slot_q;
    logic [INSTR_W-1:0] prog_q [NUM_SLOTS];

    always_comb begin
        slot_d = slot_q;
        if (!run)
            slot_d = '0;
        else if (slot_q == LAST)
            slot_d = '0;
        else
            slot_d = slot_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SLOTS; i++) prog_q[i] <= '0;
        end else if (prog_we) begin
            prog_q[prog_addr] <= prog_data;
        end
    end

    assign slot  = slot_q;
    assign instr = instr_t'(prog_q[slot_q]);

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (run && slot_q != LAST) |=> (slot_q == $past(slot_q) + 1'b1));
    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (run && slot_q == LAST) |=> (slot_q == '0));
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !run |=> (slot_q == '0));

endmodule

// File: rtl/slot_pe_nodes.sv
module slot_pe_nodes
    import slot_pe_pkg::*;
#(
    parameter int W        = 32,
    parameter int RX_WORDS = 16,
    parameter int NB_WORDS = 4,
    parameter int NDIR     = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NODE_AW-1:0]              rd_addr_a,
    input  logic [NODE_AW-1:0]              rd_addr_b,
    output logic [W-1:0]                    rd_data_a,
    output logic [W-1:0]                    rd_data_b,
    input  logic                            wr_en,
    input  logic [NODE_AW-1:0]              wr_addr,
    input  logic [W-1:0]                    wr_data,
    input  logic [NDIR-1:0]                 nb_we,
    input  logic [NDIR*$clog2(NB_WORDS)-1:0] nb_addr,
    input  logic [NDIR*W-1:0]               nb_data
);
    localparam int RX_TOTAL = 2 * RX_WORDS;
    localparam int RX_AW    = $clog2(RX_TOTAL);
    localparam int NB_AW    = $clog2(NB_WORDS);
    localparam int NB_END   = RX_TOTAL + NDIR * NB_WORDS;

    logic [W-1:0] rx_q [RX_TOTAL];
    logic [W-1:0] nb_q [NDIR][NB_WORDS];

    logic [NODE_AW-1:0] rd_addr [2];
    logic [W-1:0]       rd_data [2];

    assign rd_addr[0] = rd_addr_a;
    assign rd_addr[1] = rd_addr_b;
    assign rd_data_a  = rd_data[0];
    assign rd_data_b  = rd_data[1];

    // Two identical combinational read ports over the node map
    for (genvar p = 0; p < 2; p++) begin : g_rd
        always_comb begin
            rd_data[p] = '0;
            if (int'(rd_addr[p]) < RX_TOTAL) begin
                rd_data[p] = rx_q[rd_addr[p][RX_AW-1:0]];
            end else if (int'(rd_addr[p]) < NB_END) begin
                for (int d = 0; d < NDIR; d++) begin
                    if (int'(rd_addr[p]) >= RX_TOTAL + d * NB_WORDS &&
                        int'(rd_addr[p]) <  RX_TOTAL + (d + 1) * NB_WORDS)
                        rd_data[p] = nb_q[d][rd_addr[p][NB_AW-1:0]];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RX_TOTAL; i++) rx_q[i] <= '0;
            for (int d = 0; d < NDIR; d++)
                for (int i = 0; i < NB_WORDS; i++) nb_q[d][i] <= '0;
        end else begin
            if (wr_en && int'(wr_addr) < RX_TOTAL)
                rx_q[wr_addr[RX_AW-1:0]] <= wr_data;
            for (int d = 0; d < NDIR; d++)
                if (nb_we[d])
                    nb_q[d][nb_addr[d*NB_AW +: NB_AW]] <= nb_data[d*W +: W];
        end
    end

    // R5: a router write lands in the bank the core reads back
    a_r5_router_word: assert property (@(posedge clk) disable iff (rst)
        (nb_we[0] && !$isunknown(nb_addr[NB_AW-1:0]))
        |=> (nb_q[0][$past(nb_addr[NB_AW-1:0])] == $past(nb_data[W-1:0])));

endmodule

// File: rtl/slot_pe_dmem.sv
module slot_pe_dmem #(
    parameter int W     = 32,
    parameter int DEPTH = 2048
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [W-1:0]             wdata,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/slot_pe.sv
module slot_pe
    import slot_pe_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int NUM_SLOTS  = 16,
    parameter int DMEM_DEPTH = 2048,
    parameter int RX_WORDS   = 16,
    parameter int NB_WORDS   = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            run,
    input  logic                            prog_we,
    input  logic [$clog2(NUM_SLOTS)-1:0]    prog_addr,
    input  logic [INSTR_W-1:0]              prog_data,
    input  logic [WORD_W-1:0]               io_in,
    input  logic [1:0]                      pred_in,
    input  logic [3:0]                      nb_we,
    input  logic [4*$clog2(NB_WORDS)-1:0]   nb_addr,
    input  logic [4*WORD_W-1:0]             nb_data,
    output logic [WORD_W-1:0]               io_out,
    output logic                            io_out_vld,
    output logic [$clog2(NUM_SLOTS)-1:0]    slot_idx
);
    localparam int NDIR  = 4;
    localparam int DAW   = $clog2(DMEM_DEPTH);
    localparam int SEXT  = WORD_W - IMM_W;

    typedef struct packed {
        logic              flag;
        logic [WORD_W-1:0] io_out;
        logic              io_vld;
    } state_t;

    state_t st_d, st_q;
    instr_t ins;

    logic [WORD_W-1:0] rd_a, rd_b, node_wdata, dm_rdata, dm_wdata;
    logic              node_we, dm_we, pred_ok, exec;
    logic [DAW-1:0]    dm_addr;

    slot_pe_seq #(.NUM_SLOTS(NUM_SLOTS)) u_seq (
        .clk(clk), .rst(rst), .run(run),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
        .slot(slot_idx), .instr(ins)
    );

    slot_pe_nodes #(.W(WORD_W), .RX_WORDS(RX_WORDS), .NB_WORDS(NB_WORDS), .NDIR(NDIR)) u_nodes (
        .clk(clk), .rst(rst),
        .rd_addr_a(ins.a), .rd_addr_b(ins.b),
        .rd_data_a(rd_a), .rd_data_b(rd_b),
        .wr_en(node_we), .wr_addr(ins.a), .wr_data(node_wdata),
        .nb_we(nb_we), .nb_addr(nb_addr), .nb_data(nb_data)
    );

    slot_pe_dmem #(.W(WORD_W), .DEPTH(DMEM_DEPTH)) u_dmem (
        .clk(clk), .we(dm_we), .addr(dm_addr),
        .wdata(dm_wdata), .rdata(dm_rdata)
    );

    always_comb begin
        unique case (ins.pred)
            PR_ALWAYS: pred_ok = 1'b1;
            PR_FLAG:   pred_ok = st_q.flag;
            PR_BIT0:   pred_ok = pred_in[0];
            PR_BIT1:   pred_ok = pred_in[1];
            default:   pred_ok = 1'b0;
        endcase
        exec = run && pred_ok;
    end

    always_comb begin
        st_d        = st_q;
        st_d.io_vld = 1'b0;
        node_we     = 1'b0;
        node_wdata  = '0;
        dm_we       = 1'b0;
        dm_wdata    = rd_b;
        dm_addr     = ((ins.op == OP_STORE) ? rd_a[DAW-1:0] : rd_b[DAW-1:0])
                      + ins.imm[DAW-1:0];
        case (ins.op)
            OP_LOAD: begin
                node_we    = exec;
                node_wdata = dm_rdata;
            end
            OP_STORE: begin
                dm_we = exec;
            end
            OP_IOLD: begin
                node_we    = exec;
                node_wdata = io_in;
            end
            OP_IOST: begin
                if (exec) begin
                    st_d.io_out = rd_b;
                    st_d.io_vld = 1'b1;
                end
            end
            OP_ADDI: begin
                node_we    = exec;
                node_wdata = rd_b + {{SEXT{ins.imm[IMM_W-1]}}, ins.imm};
            end
            OP_ADD: begin
                node_we    = exec;
                node_wdata = rd_a + rd_b;
            end
            OP_CMP: begin
                if (exec) st_d.flag = |rd_b;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign io_out     = st_q.io_out;
    assign io_out_vld = st_q.io_vld;

    a_r6_out_hold: assert property (@(posedge clk) disable iff (rst)
        !st_d.io_vld |=> (io_out == $past(io_out)));
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !run |=> !io_out_vld);
    a_r10_flag_keep: assert property (@(posedge clk) disable iff (rst)
        (ins.op != OP_CMP || !exec) |=> (st_q.flag == $past(st_q.flag)));
    a_r10_no_write: assert property (@(posedge clk) disable iff (rst)
        !exec |-> (!node_we && !dm_we && !st_d.io_vld));

endmodule

// File: tb/tb_slot_pe.sv
module tb_slot_pe;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;
    localparam int WATCHDOG   = 20000;

    logic          clk = 1'b0;
    logic          rst, run, prog_we;
    logic [3:0]    prog_addr;
    logic [33:0]   prog_data;
    logic [W-1:0]  io_in;
    logic [1:0]    pred_in;
    logic [3:0]    nb_we;
    logic [7:0]    nb_addr;
    logic [127:0]  nb_data;
    logic [W-1:0]  io_out;
    logic          io_out_vld;
    logic [3:0]    slot_idx;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [W-1:0] exp_q [$];
    string        tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_pe dut (
        .clk(clk), .rst(rst), .run(run),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
        .io_in(io_in), .pred_in(pred_in),
        .nb_we(nb_we), .nb_addr(nb_addr), .nb_data(nb_data),
        .io_out(io_out), .io_out_vld(io_out_vld), .slot_idx(slot_idx)
    );

    // R3 encoding: op[33:30] pred[29:28] A[27:22] B[21:16] imm[15:0]
    function automatic logic [33:0] enc(int op, int pr, int a, int b, int imm);
        return {4'(op), 2'(pr), 6'(a), 6'(b), 16'(imm)};
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_out(logic [W-1:0] v, string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // monitor: pop one expectation per strobe
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && io_out_vld) begin
                n_tests++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R6 unexpected output actual=%h expected=none", io_out);
                end else begin
                    logic [W-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (io_out !== e) begin
                        n_fail++;
                        $display("FAIL %s actual=%h expected=%h", t, io_out, e);
                    end
                end
            end
        end
    end

    task automatic do_reset();
        rst = 1'b1; run = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load(input logic [33:0] p [16]);
        for (int i = 0; i < 16; i++) begin
            prog_we = 1'b1; prog_addr = 4'(i); prog_data = p[i];
            @(negedge clk);
        end
        prog_we = 1'b0;
    endtask

    task automatic nb_write(int d, int idx, logic [W-1:0] v);
        nb_we = '0;
        nb_we[d] = 1'b1;
        nb_addr[d*2 +: 2] = 2'(idx);
        nb_data[d*W +: W] = v;
    endtask

    // one full user cycle, starting at the negedge before slot 0 executes
    task automatic user_cycle(logic [1:0] pr, logic [W-1:0] din, bit nbw, logic [W-1:0] nbv);
        pred_in = pr; io_in = din; run = 1'b1;
        check("R2 slot at cycle start", W'(slot_idx), 0);
        if (nbw) nb_write(0, 0, nbv);
        for (int i = 1; i <= 16; i++) begin
            @(negedge clk);
            nb_we = '0;
            if (i == 7) check("R2 slot step", W'(slot_idx), 7);
            if (i == 15) check("R2 slot last", W'(slot_idx), 15);
        end
    endtask

    initial begin
        logic [33:0] pa [16];
        logic [33:0] pb [16];
        prog_we = 0; prog_addr = 0; prog_data = 0; io_in = 0; pred_in = 0;
        nb_we = 0; nb_addr = 0; nb_data = 0; rst = 1; run = 0;

        do_reset();
        // R1 reset state
        check("R1 slot", W'(slot_idx), 0);
        check("R1 vld", W'(io_out_vld), 0);
        check("R1 out", io_out, 0);

        // program A: predicated FIFO on R0 (tail) / R1 (head) plus a countdown in R8
        for (int i = 0; i < 16; i++) pa[i] = '0;
        pa[0] = enc(3, 0, 2, 0, 0);           // IOLOAD R2
        pa[1] = enc(2, 2, 0, 2, 16'h07FF);    // STORE.bit0 [R0+2047], R2
        pa[2] = enc(5, 2, 0, 0, 1);           // ADDI.bit0 R0,R0,1
        pa[3] = enc(1, 3, 3, 1, 16'h07FF);    // LOAD.bit1 R3,[R1+2047]
        pa[4] = enc(4, 3, 0, 3, 0);           // IOSTORE.bit1 R3
        pa[5] = enc(5, 3, 1, 1, 1);           // ADDI.bit1 R1,R1,1
        pa[6] = enc(5, 0, 8, 8, 16'hFFFE);    // ADDI R8,R8,-2
        pa[7] = enc(4, 0, 0, 8, 0);           // IOSTORE R8
        pa[9] = enc(12, 0, 9, 9, 5);          // unused code acts as no-op (R3)
        load(pa);

        // R8 R10: write gated by bit0, read gated by bit1; R7 negative immediate
        expect_out(32'hFFFFFFFE, "R7 addi negative c0");
        user_cycle(2'b01, 32'h11, 0, 0);
        expect_out(32'hFFFFFFFC, "R7 addi c1");
        user_cycle(2'b01, 32'h22, 0, 0);
        expect_out(32'h11, "R8 load first word");
        expect_out(32'hFFFFFFFA, "R7 addi c2");
        user_cycle(2'b10, 32'h99, 0, 0);
        expect_out(32'h22, "R8 load second word");
        expect_out(32'hFFFFFFF8, "R7 addi c3");
        user_cycle(2'b11, 32'h33, 0, 0);
        expect_out(32'hFFFFFFF6, "R10 both bits low, no fifo output");
        user_cycle(2'b00, 32'h44, 0, 0);
        expect_out(32'h33, "R8 load third word");
        expect_out(32'hFFFFFFF4, "R7 addi c5");
        user_cycle(2'b10, 32'h66, 0, 0);
        expect_out(32'h55, "R11 store then load same cycle (R10 suppressed write skipped)");
        expect_out(32'hFFFFFFF2, "R7 addi c6");
        user_cycle(2'b11, 32'h55, 0, 0);

        // R2 stop: slot holds 0, nothing executes
        run = 1'b0;
        repeat (4) @(negedge clk);
        check("R2 idle slot", W'(slot_idx), 0);
        check("R2 idle no strobe", W'(io_out_vld), 0);
        check("R6 output held", io_out, 32'hFFFFFFF2);
        check("R8 all expected outputs seen", W'(exp_q.size()), 0);

        do_reset();
        check("R1 out after second reset", io_out, 0);

        // program B: compare flag, register/wire order, neighbour banks, address map
        for (int i = 0; i < 16; i++) pb[i] = '0;
        pb[0]  = enc(3, 0, 4, 0, 0);    // IOLOAD R4
        pb[1]  = enc(7, 0, 0, 4, 0);    // CMP R4
        pb[2]  = enc(5, 1, 5, 5, 1);    // ADDI.flag R5,R5,1
        pb[3]  = enc(4, 0, 0, 5, 0);    // IOSTORE R5
        pb[4]  = enc(4, 0, 0, 16, 0);   // IOSTORE X0 (old value)
        pb[5]  = enc(6, 0, 16, 4, 0);   // ADD X0,X0,R4
        pb[6]  = enc(5, 0, 6, 32, 0);   // R6 = N0
        pb[7]  = enc(6, 0, 6, 42, 0);   // R6 += E2
        pb[8]  = enc(4, 0, 0, 6, 0);    // IOSTORE R6
        pb[9]  = enc(7, 0, 0, 7, 0);    // CMP R7 (zero)
        pb[10] = enc(4, 1, 0, 4, 0);    // IOSTORE.flag R4
        pb[11] = enc(7, 2, 0, 4, 0);    // CMP.bit0 R4
        pb[12] = enc(4, 1, 0, 5, 0);    // IOSTORE.flag R5
        pb[13] = enc(5, 0, 33, 4, 0);   // write to N1: dropped
        pb[14] = enc(4, 0, 0, 33, 0);   // IOSTORE N1
        pb[15] = enc(4, 0, 0, 50, 0);   // IOSTORE addr 50 (hole)
        load(pb);

        // R5 router writes while idle
        nb_write(0, 0, 100); @(negedge clk);
        nb_write(0, 1, 7);   @(negedge clk);
        nb_write(2, 2, 5);   @(negedge clk);
        nb_write(1, 0, 999); @(negedge clk);
        nb_we = '0;

        // c0 v=3 bit0=1
        expect_out(1,   "R9 flag set by nonzero");
        expect_out(0,   "R1 X cleared / R11 register old value");
        expect_out(105, "R5 N0+E2");
        expect_out(1,   "R10 cmp on bit0 then flag store");
        expect_out(7,   "R4 write to N1 dropped");
        expect_out(0,   "R4 hole reads zero");
        user_cycle(2'b01, 3, 0, 0);
        // c1 v=0 bit0=1
        expect_out(1,   "R9 flag cleared by zero");
        expect_out(3,   "R11 register holds last cycle sum");
        expect_out(105, "R5 c1");
        expect_out(7,   "R4 c1");
        expect_out(0,   "R4 hole c1");
        user_cycle(2'b01, 0, 0, 0);
        // c2 v=4 bit0=0, N0 rewritten in slot 0
        expect_out(2,   "R9 count");
        expect_out(3,   "R11 register c2");
        expect_out(205, "R5 router write mid-run");
        expect_out(7,   "R10 suppressed cmp keeps flag clear");
        expect_out(0,   "R4 hole c2");
        user_cycle(2'b00, 4, 1, 200);
        // c3 v=5 bit0=1
        expect_out(3,   "R9 count c3");
        expect_out(7,   "R7 add accumulate");
        expect_out(205, "R5 c3");
        expect_out(3,   "R10 flag store c3");
        expect_out(7,   "R4 c3");
        expect_out(0,   "R4 hole c3");
        user_cycle(2'b01, 5, 0, 0);

        run = 1'b0;
        repeat (4) @(negedge clk);
        check("R6 no missing outputs", W'(exp_q.size()), 0);
        check("R2 idle slot end", W'(slot_idx), 0);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule